// File: doc/BRIEF.md
# Bus clock-low timeout monitor

This block sits beside a two-wire serial bus master and guards against a target device that stretches the clock without end. At each START event it loads a 12-bit down-counter from an 8-bit programmed limit, placed above four zero bits. It then counts down once for every falling edge of the master's own internal bit clock. That clock keeps running at the programmed bus rate even while the external clock line is held low, so the count measures the total time elapsed since START, whatever the line level. If the counter reaches its terminal count before a STOP event, the monitor does three things: it sets a sticky timeout flag, pulses an interrupt for one cycle, and raises an abort request. The master state machine answers that request by issuing a STOP once both lines are released.

The limit is read only at START. A limit of 0x00 or 0x01 is not a valid limit: with it, no START arms the monitor. With a 100 kHz bit clock, a limit of 0xDA loads 0xDA0 (3488 edges, about 34.9 ms), and a limit of 0x7D gives about 20 ms. The flag is cleared by a write-one-to-clear strobe. The abort request stays high until the master signals that its STOP is complete.

Top module: `clk_low_timeout_mon`

## Requirements
- R1: After reset, `timeout_o`, `irq_o` and `abort_req_o` are all low.
- R2: A START with a valid limit L (L >= 2) loads L*16, the limit in bits 11:4 and zero in bits 3:0. A timeout occurs on exactly the L*16-th `bit_fall_i` strobe after that START. For example, L=0xDA gives 3488 strobes.
- R3: A START with L equal to 0x00 or 0x01 leaves the monitor unarmed, and no number of strobes then reports a timeout.
- R4: `timeout_o` rises in the cycle after the terminal strobe. The monitor then disarms, so further strobes raise no new interrupt.
- R5: `irq_o` is high for exactly one cycle, in the cycle where `timeout_o` first becomes high.
- R6: `timeout_o` stays high until a `flag_clr_i` strobe clears it. If a new timeout and a clear fall in the same cycle, the timeout wins.
- R7: `abort_req_o` rises together with `timeout_o` and stays high until `abort_done_i`. It does not depend on `flag_clr_i`. If a new timeout and `abort_done_i` fall in the same cycle, the timeout wins.
- R8: A STOP before the terminal strobe disarms the counter, and no timeout is reported.
- R9: A START while the counter is armed reloads it from the current limit. A START and a STOP in the same cycle act as a START.
- R10: Only cycles with `bit_fall_i` high decrement the count. A change of `limit_i` after START does not affect the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_fall_i | input | 1 | One-cycle strobe per falling edge of the master's internal bit clock |
| start_i | input | 1 | One-cycle strobe on a START condition |
| stop_i | input | 1 | One-cycle strobe on a STOP condition |
| limit_i | input | 8 | Programmed limit, upper bits of the load value |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the timeout flag |
| abort_done_i | input | 1 | Master reports that the abort STOP is complete |
| timeout_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | One-cycle interrupt pulse when the flag sets |
| abort_req_o | output | 1 | Request to the master to abort with a STOP |

## Verification
Every result is due one clock after the input that causes it. If the terminal strobe is sampled at edge k, then `timeout_o`, `irq_o` and `abort_req_o` all become visible after edge k, and `irq_o` falls again after edge k+1. Clears and acknowledgements also act one edge after their strobe. The bench drives its inputs on the falling clock edge and updates a behavioural model at each rising edge from the same sampled inputs. It compares all three outputs 2 ns after that edge, and also makes directed checks at the falling edge that follows a stimulus task, when all outputs due from that stimulus have already settled.

// File: rtl/clto_pkg.sv
package clto_pkg;

  // Operation selected for the down-counter in a given cycle.
  typedef enum logic [1:0] {
    CNT_IDLE   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_DISARM = 2'd2,
    CNT_TICK   = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/clto_rst_sync.sv
module clto_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/clto_limit_dec.sv
module clto_limit_dec #(
  parameter int unsigned LIM_W = 8,
  parameter int unsigned CNT_W = 12
) (
  input  logic [LIM_W-1:0] limit_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] load_o
);

  localparam int unsigned FRAC_W = CNT_W - LIM_W;

  // Values 0 and 1 are not valid limits; any bit above bit 0 makes it valid.
  assign valid_o = |limit_i[LIM_W-1:1];

  generate
    if (FRAC_W > 0) begin : g_frac
      assign load_o = {limit_i, {FRAC_W{1'b0}}};
    end else begin : g_nofrac
      assign load_o = limit_i[LIM_W-1 -: CNT_W];
    end
  endgenerate

endmodule

// File: rtl/clto_counter.sv
module clto_counter
  import clto_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             armed_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  // Priority: START over STOP over a bit-clock tick.
  always_comb begin
    if (start_i)                op = CNT_LOAD;
    else if (stop_i)            op = CNT_DISARM;
    else if (armed_q && tick_i) op = CNT_TICK;
    else                        op = CNT_IDLE;
  end

  always_comb begin
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    expire_o = 1'b0;
    unique case (op)
      CNT_LOAD: begin
        armed_d = valid_i;
        cnt_d   = valid_i ? load_i : '0;
      end
      CNT_DISARM: begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end
      CNT_TICK: begin
        if (cnt_q == LAST) begin
          expire_o = 1'b1;
          armed_d  = 1'b0;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q - LAST;
        end
      end
      default: ;
    endcase
  end

  assign cnt_en = (op != CNT_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  p_armed_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q != '0));

  p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && valid_i) |=> (armed_q && cnt_q == $past(load_i)));

  p_invalid_no_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> !armed_q);

  p_stop_disarms_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !armed_q);

  p_no_tick_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !tick_i) |=> ($stable(cnt_q) && $stable(armed_q)));

endmodule

// File: rtl/clto_status.sv
module clto_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic flag_clr_i,
  input  logic abort_done_i,
  output logic flag_o,
  output logic irq_o,
  output logic abort_o
);

  logic flag_q, flag_d;
  logic irq_q, irq_d;
  logic abort_q, abort_d;

  always_comb begin
    flag_d  = flag_q;
    abort_d = abort_q;
    irq_d   = expire_i;
    if (expire_i)          flag_d = 1'b1;
    else if (flag_clr_i)   flag_d = 1'b0;
    if (expire_i)          abort_d = 1'b1;
    else if (abort_done_i) abort_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      irq_q   <= irq_d;
      abort_q <= abort_d;
    end
  end

  assign flag_o  = flag_q;
  assign irq_o   = irq_q;
  assign abort_o = abort_q;

  p_irq_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  p_irq_with_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (flag_q && abort_q));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);

  p_abort_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && !abort_done_i) |=> abort_q);

endmodule

// File: rtl/clk_low_timeout_mon.sv
module clk_low_timeout_mon #(
  parameter int unsigned LIM_W = 8,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             flag_clr_i,
  input  logic             abort_done_i,
  output logic             timeout_o,
  output logic             irq_o,
  output logic             abort_req_o
);

  logic             rst_n;
  logic             lim_valid;
  logic [CNT_W-1:0] lim_load;
  logic             armed;
  logic             expire;

  clto_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  clto_limit_dec #(.LIM_W(LIM_W), .CNT_W(CNT_W)) u_dec (
    .limit_i(limit_i),
    .valid_o(lim_valid),
    .load_o (lim_load)
  );

  clto_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .tick_i  (bit_fall_i),
    .valid_i (lim_valid),
    .load_i  (lim_load),
    .armed_o (armed),
    .expire_o(expire)
  );

  clto_status u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .expire_i    (expire),
    .flag_clr_i  (flag_clr_i),
    .abort_done_i(abort_done_i),
    .flag_o      (timeout_o),
    .irq_o       (irq_o),
    .abort_o     (abort_req_o)
  );

  p_expire_disarms_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    expire |=> (!armed && irq_o));

endmodule

// File: tb/tb_clk_low_timeout_mon.sv
`timescale 1ns/1ps
module tb_clk_low_timeout_mon;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_fall = 1'b0, start = 1'b0, stop = 1'b0;
  logic [7:0] limit = 8'h00;
  logic       clr = 1'b0, done = 1'b0;
  logic       timeout, irq, abort_req;

  int errors = 0;
  int checks = 0;
  bit in_reset = 1'b1;
  bit finished = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt = 0;
  bit m_armed = 0, m_flag = 0, m_irq = 0, m_abort = 0;

  always #5 clk = ~clk;

  clk_low_timeout_mon dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_fall_i(bit_fall), .start_i(start),
    .stop_i(stop), .limit_i(limit), .flag_clr_i(clr), .abort_done_i(done),
    .timeout_o(timeout), .irq_o(irq), .abort_req_o(abort_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at each rising edge, compare shortly after
  always @(posedge clk) begin
    bit exp_now;
    exp_now = 0;
    if (in_reset) begin
      m_cnt = 0; m_armed = 0; m_flag = 0; m_irq = 0; m_abort = 0;
    end else begin
      if (start) begin
        m_armed = (limit > 1);
        m_cnt   = m_armed ? limit * 16 : 0;
      end else if (stop) begin
        m_armed = 0;
      end else if (m_armed && bit_fall) begin
        if (m_cnt == 1) begin
          exp_now = 1; m_armed = 0; m_cnt = 0;
        end else begin
          m_cnt--;
        end
      end
      if (exp_now) m_flag = 1; else if (clr) m_flag = 0;
      if (exp_now) m_abort = 1; else if (done) m_abort = 0;
      m_irq = exp_now;
    end
    #2;
    if (!in_reset && !finished) begin
      check({cur_req, " model timeout"}, timeout, m_flag);
      check({cur_req, " model irq"}, irq, m_irq);
      check({cur_req, " model abort"}, abort_req, m_abort);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic [7:0] lim);
    limit = lim; start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_done();
    done = 1'b1; @(negedge clk); done = 1'b0;
  endtask

  task automatic falls(input int n);
    if (n > 0) begin
      bit_fall = 1'b1; repeat (n) @(negedge clk); bit_fall = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(4);
    rst_ni = 1'b1;
    cyc(4);
    in_reset = 1'b0;

    // R1: reset state
    cur_req = "R1";
    check("R1 timeout after reset", timeout, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 abort after reset", abort_req, 0);

    // R2/R4/R5/R7: limit 2 -> 32 strobes
    cur_req = "R2";
    do_start(8'h02);
    falls(31);
    check("R2 no timeout after 31 strobes", timeout, 0);
    falls(1);
    check("R4 timeout after 32nd strobe", timeout, 1);
    check("R5 irq with flag", irq, 1);
    check("R7 abort with flag", abort_req, 1);
    cyc(1);
    check("R5 irq one cycle", irq, 0);
    cur_req = "R4";
    falls(40);
    check("R4 disarmed, no new irq", irq, 0);
    cur_req = "R7";
    cyc(3);
    check("R7 abort held", abort_req, 1);
    cur_req = "R6";
    do_clr();
    check("R6 clear flag", timeout, 0);
    check("R7 abort unaffected by clear", abort_req, 1);
    cur_req = "R7";
    do_done();
    check("R7 abort dropped on done", abort_req, 0);

    // R3: invalid limits
    cur_req = "R3";
    do_start(8'h00);
    falls(5000);
    check("R3 limit 0 never times out", timeout, 0);
    do_start(8'h01);
    falls(100);
    check("R3 limit 1 never times out", timeout, 0);

    // R8: stop before terminal
    cur_req = "R8";
    do_start(8'h03);
    falls(47);
    do_stop();
    falls(10);
    check("R8 stop disarms", timeout, 0);

    // R9: restart reloads; start+stop acts as start
    cur_req = "R9";
    do_start(8'h02);
    falls(20);
    do_start(8'h02);
    falls(31);
    check("R9 reload no early timeout", timeout, 0);
    falls(1);
    check("R9 reload timeout at 32", timeout, 1);
    do_clr(); do_done();
    limit = 8'h02; start = 1'b1; stop = 1'b1; @(negedge clk);
    start = 1'b0; stop = 1'b0;
    falls(32);
    check("R9 start wins over stop", timeout, 1);
    do_clr(); do_done();

    // R10: sparse strobes, limit change after start ignored
    cur_req = "R10";
    do_start(8'h02);
    limit = 8'hFF;
    for (int i = 0; i < 32; i++) begin
      bit_fall = 1'b1; @(negedge clk); bit_fall = 1'b0;
      cyc(2);
      if (i == 30) check("R10 no timeout after 31 sparse strobes", timeout, 0);
    end
    check("R10 timeout on 32nd sparse strobe", timeout, 1);
    do_clr(); do_done();

    // R6/R7: set wins over clear and done
    cur_req = "R6";
    do_start(8'h02);
    falls(31);
    bit_fall = 1'b1; clr = 1'b1; done = 1'b1; @(negedge clk);
    bit_fall = 1'b0; clr = 1'b0; done = 1'b0;
    check("R6 set wins over clear", timeout, 1);
    check("R7 set wins over done", abort_req, 1);
    do_clr(); do_done();

    // R2: programmed 0xDA -> 3488 strobes
    cur_req = "R2";
    do_start(8'hDA);
    falls(3487);
    check("R2 0xDA no timeout at 3487", timeout, 0);
    falls(1);
    check("R2 0xDA timeout at 3488", timeout, 1);
    cyc(2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule